// File: doc/BRIEF.md
# Twelve-Bit ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for 12-bit operands. A 3-bit operation code picks one of eight functions: three bitwise logic functions, complement of A, and four two's-complement arithmetic functions (add, subtract, increment, decrement). Alongside the 12-bit result it drives three flags: signed overflow, adder carry and an all-zero indication.

Internally a small control decoder turns the operation code into a struct of strobes. The strobes pick what the B operand becomes (passed, inverted, forced to zero or forced to all ones), the adder carry-in, and which of four sources reaches the output: AND, OR, XOR or the adder. Complement reuses the XOR source and increment/decrement reuse the adder. The adder is built from two 6-bit lookahead slices. The carry-out of the low slice feeds the carry-in of the high slice.

Top module: `alu12`

## Requirements
- R1: Codes 000, 001 and 010 give the bitwise AND, OR and XOR of A and B respectively.
- R2: Code 011 gives the bitwise complement of A, whatever B is.
- R3: Code 100 gives (A + B) mod 4096, and carry equals bit 12 of the 13-bit sum.
- R4: Code 101 gives (A - B) mod 4096, computed as A + ~B + 1. Carry is bit 12 of that sum, so it is 1 when A >= B unsigned.
- R5: Code 110 gives (A + 1) mod 4096. Carry is 1 only when A = 0xFFF.
- R6: Code 111 gives (A - 1) mod 4096, computed as A + 0xFFF. Carry is 1 except when A = 0.
- R7: For codes 100 to 111, overflow is 1 exactly when the signed 12-bit result differs from the true signed result. This happens when the adder's effective operands share a sign and the result sign differs from it.
- R8: For codes 000 to 011, carry and overflow are both 0.
- R9: For every code, zero is 1 exactly when the 12-bit result is 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aIn | input | 12 | Operand A |
| bIn | input | 12 | Operand B |
| opSel | input | 3 | Operation code |
| aluOut | output | 12 | Result |
| ovf | output | 1 | Signed overflow flag |
| carry | output | 1 | Adder carry-out flag |
| zero | output | 1 | Result-is-zero flag |

## Verification
The embedded checks hold at every input change:
- logic codes never raise carry or overflow;
- complement and increment match independently computed values;
- a raised overflow always comes with matching operand signs and a flipped result sign;
- each lookahead slice agrees with a plain sum.

Only the bench's scenarios can show the rest:
- the full result and flag values for every code;
- carry crossing the slice boundary;
- the edge operands 0, 1, 0x7FF, 0x800 and 0xFFF.

// File: rtl/alu12_pkg.sv
package alu12_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_XOR = 3'b010,
    OP_NOT = 3'b011,
    OP_ADD = 3'b100,
    OP_SUB = 3'b101,
    OP_INC = 3'b110,
    OP_DEC = 3'b111
  } aluOp_t;

  typedef enum logic [1:0] {
    SRC_AND = 2'd0,
    SRC_OR  = 2'd1,
    SRC_XOR = 2'd2,
    SRC_SUM = 2'd3
  } srcSel_t;

  typedef enum logic [1:0] {
    B_PASS = 2'd0,
    B_INV  = 2'd1,
    B_ZERO = 2'd2,
    B_ONES = 2'd3
  } bMode_t;

  typedef struct packed {
    srcSel_t src;
    bMode_t  bMode;
    logic    carryIn;
    logic    arith;
  } aluCtrl_t;

endpackage

// File: rtl/alu12_cla.sv
module alu12_cla #(
  parameter int W = 6
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output logic [W:1]   carry
);
  logic [W-1:0] gen, prop;
  logic [W:0]   cl;

  assign gen = aIn & bIn;
  assign prop = aIn ^ bIn;

  // each carry is a flat sum of products of gen/prop and cIn, no chaining
  always_comb begin
    cl = '0;
    cl[0] = cIn;
    for (int k = 1; k <= W; k++) begin
      logic term;
      logic acc;
      term = cIn;
      for (int j = 0; j < k; j++) term = term & prop[j];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      cl[k] = acc;
    end
  end

  assign sum = prop ^ cl[W-1:0];
  assign carry = cl[W:1];

  always_comb begin
    // R3
    cla_sum_chk: assert ({carry[W], sum} == ({1'b0, aIn} + {1'b0, bIn} + {{W{1'b0}}, cIn}));
  end
endmodule

// File: rtl/alu12_ctrl.sv
module alu12_ctrl
  import alu12_pkg::*;
(
  input  logic [2:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '{src: SRC_AND, bMode: B_PASS, carryIn: 1'b0, arith: 1'b0};
    unique case (aluOp_t'(opSel))
      OP_AND: ctrl.src = SRC_AND;
      OP_OR:  ctrl.src = SRC_OR;
      OP_XOR: ctrl.src = SRC_XOR;
      OP_NOT: begin ctrl.src = SRC_XOR; ctrl.bMode = B_ONES; end
      OP_ADD: begin ctrl.src = SRC_SUM; ctrl.arith = 1'b1; end
      OP_SUB: begin ctrl.src = SRC_SUM; ctrl.bMode = B_INV;  ctrl.carryIn = 1'b1; ctrl.arith = 1'b1; end
      OP_INC: begin ctrl.src = SRC_SUM; ctrl.bMode = B_ZERO; ctrl.carryIn = 1'b1; ctrl.arith = 1'b1; end
      OP_DEC: begin ctrl.src = SRC_SUM; ctrl.bMode = B_ONES; ctrl.arith = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    // R8
    ctrl_arith_src_chk: assert (ctrl.arith == (ctrl.src == SRC_SUM));
  end
endmodule

// File: rtl/alu12_datapath.sv
module alu12_datapath
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int SLICE = 6
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             carry,
  output logic             zero
);
  localparam int NSLICE = WIDTH / SLICE;

  logic [WIDTH-1:0] bEff, sumVal;
  logic [WIDTH:0]   carryAll;

  always_comb begin
    unique case (ctrl.bMode)
      B_PASS:  bEff = bIn;
      B_INV:   bEff = ~bIn;
      B_ZERO:  bEff = '0;
      default: bEff = '1;
    endcase
  end

  assign carryAll[0] = ctrl.carryIn;

  // lookahead slices chained by a ripple carry between them
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    alu12_cla #(.W(SLICE)) u_cla (
      .aIn   (aIn[s*SLICE +: SLICE]),
      .bIn   (bEff[s*SLICE +: SLICE]),
      .cIn   (carryAll[s*SLICE]),
      .sum   (sumVal[s*SLICE +: SLICE]),
      .carry (carryAll[s*SLICE+1 +: SLICE])
    );
  end

  always_comb begin
    unique case (ctrl.src)
      SRC_AND: result = aIn & bEff;
      SRC_OR:  result = aIn | bEff;
      SRC_XOR: result = aIn ^ bEff;
      default: result = sumVal;
    endcase
  end

  assign ovf = ctrl.arith & (carryAll[WIDTH-1] ^ carryAll[WIDTH]);
  assign carry = ctrl.arith & carryAll[WIDTH];
  assign zero = (result == '0);

  always_comb begin
    if (ovf) begin
      // R7
      ovf_sign_chk: assert ((aIn[WIDTH-1] == bEff[WIDTH-1]) && (result[WIDTH-1] != aIn[WIDTH-1]));
    end
  end
endmodule

// File: rtl/alu12.sv
module alu12
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int SLICE = 6
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] aluOut,
  output logic             ovf,
  output logic             carry,
  output logic             zero
);
  aluCtrl_t ctrl;

  alu12_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu12_datapath #(.WIDTH(WIDTH), .SLICE(SLICE)) u_dp (
    .aIn    (aIn),
    .bIn    (bIn),
    .ctrl   (ctrl),
    .result (aluOut),
    .ovf    (ovf),
    .carry  (carry),
    .zero   (zero)
  );

  always_comb begin
    if (!opSel[2]) begin
      // R8
      no_logic_flags_chk: assert (!carry && !ovf);
    end
    if (opSel == OP_NOT) begin
      // R2
      not_result_chk: assert (aluOut == ~aIn);
    end
    if (opSel == OP_INC) begin
      // R5
      inc_result_chk: assert (aluOut == WIDTH'(aIn + 1'b1));
    end
    if (opSel == OP_SUB && aIn == bIn) begin
      // R4
      sub_equal_chk: assert (zero && carry);
    end
  end
endmodule

// File: tb/alu12_test.sv
module alu12_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] aIn = '0, bIn = '0;
  logic [2:0]  opSel = '0;
  logic [11:0] aluOut;
  logic ovf, carry, zero;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu12 uut (.aIn(aIn), .bIn(bIn), .opSel(opSel), .aluOut(aluOut),
             .ovf(ovf), .carry(carry), .zero(zero));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, opSel, aIn, bIn, act, exp);
    end
  endtask

  // returns {ovf, carry, result}
  function automatic logic [13:0] model(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    logic [12:0] s;
    logic [11:0] bb;
    logic cin;
    case (op)
      3'd0: return {2'b00, a & b};
      3'd1: return {2'b00, a | b};
      3'd2: return {2'b00, a ^ b};
      3'd3: return {2'b00, ~a};
      default: begin
        case (op)
          3'd4: begin bb = b;       cin = 1'b0; end
          3'd5: begin bb = ~b;      cin = 1'b1; end
          3'd6: begin bb = 12'h000; cin = 1'b1; end
          default: begin bb = 12'hFFF; cin = 1'b0; end
        endcase
        s = {1'b0, a} + {1'b0, bb} + {12'b0, cin};
        return {(a[11] == bb[11]) && (s[11] != a[11]), s[12], s[11:0]};
      end
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [11:0] a, input logic [11:0] b);
    logic [13:0] e;
    @(negedge clk);
    opSel = op; aIn = a; bIn = b;
    @(posedge clk); #1;
    e = model(op, a, b);
    check(opTag(op), aluOut, e[11:0]);
    if (op[2]) begin
      check(opTag(op), carry, e[12]);
      check("R7", ovf, e[13]);
    end else begin
      check("R8", {ovf, carry}, 0);
    end
    check("R9", zero, int'(e[11:0] == 12'h000));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] corner [5];
    int unsigned seed;
    corner[0] = 12'h000; corner[1] = 12'h001; corner[2] = 12'h7FF;
    corner[3] = 12'h800; corner[4] = 12'hFFF;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1;
    // R9 initial state: AND of zeros gives zero result with zero flag
    check("R9", {aluOut, zero}, {12'h000, 1'b1});
    check("R8", {ovf, carry}, 0);
    // directed cases
    apply(3'd4, 12'h03F, 12'h001);   // R3 carry crosses slice boundary
    apply(3'd4, 12'hFFF, 12'h001);   // R3 wrap with carry
    apply(3'd4, 12'h7FF, 12'h001);   // R7 positive overflow
    apply(3'd5, 12'h800, 12'h001);   // R7 negative overflow
    apply(3'd5, 12'h123, 12'h123);   // R4 equal operands
    apply(3'd6, 12'hFFF, 12'h555);   // R5 B ignored
    apply(3'd7, 12'h000, 12'hAAA);   // R6 borrow case
    apply(3'd3, 12'h5A5, 12'h3C3);   // R2 B ignored
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(3'(op), corner[i], corner[j]);
    for (int n = 0; n < 800; n++)
      apply(3'($urandom_range(0, 7)), 12'($urandom()), 12'($urandom()));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule